// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a virtual address into a physical address by reading a tree of page tables held in memory. A walk starts from a root table frame number. Three 9-bit index fields of the virtual address, taken most significant first, pick one 8-byte entry in each level. The block issues exactly one memory read per level it visits. Each entry it reads either points to the next table, ends the walk with a fault, or ends it with a leaf mapping.

A leaf found at an upper level is a superpage. A top-level leaf maps 1 GiB and a middle-level leaf maps 2 MiB. In either case the walk stops early, and the virtual index bits below that level pass straight into the physical address.

A client starts a walk by raising `start` for one cycle while the block is idle. It then waits for a one-cycle `done` pulse. At that point the result outputs hold either a physical address with its permission bits, or a fault cause with the level at which the walk stopped. Memory is reached through a request channel with valid/ready flow control and a response channel qualified by a valid bit.

Top module: `pt_walker`

## Requirements
- R1: After reset `busy`, `done` and `mem_req_valid` are all low.
- R2: The first read goes to `root_ppn`·4096 + `va[38:30]`·8. The read at the middle level uses `va[29:21]`, and the read at the last level uses `va[20:12]`. Each of these reads is made relative to the frame named by the entry read just before it.
- R3: Entry format: bit 0 is valid, bit 1 is leaf, bits 4:2 are permissions, and bits 39:12 are a frame number. A valid non-leaf entry at levels 0 or 1 sends the walk to that frame. A valid leaf at level 2 ends the walk after 3 reads with `pa` = frame·4096 + `va[11:0]`, and `end_level` is 2.
- R4: A valid leaf at level 0 whose frame number has its low 18 bits clear ends the walk after 1 read. `pa[29:0]` equals `va[29:0]` and `pa[39:30]` comes from the frame.
- R5: A valid leaf at level 1 whose frame number has its low 9 bits clear ends the walk after 2 reads. `pa[20:0]` equals `va[20:0]` and `pa[39:21]` comes from the frame.
- R6: An entry with bit 0 clear ends the walk at once with `fault` high, `fault_cause` 1, and `end_level` equal to the level read.
- R7: A valid non-leaf entry at level 2 ends the walk with `fault` high, `fault_cause` 2, and `end_level` 2.
- R8: A superpage leaf whose frame number has any of its pass-through bits set ends the walk with `fault` high, `fault_cause` 3, and `end_level` equal to the leaf's level.
- R9: On a successful walk `perm` equals bits 4:2 of the leaf entry, `fault` is low, and `fault_cause` is 0.
- R10: `done` is high for exactly one cycle per walk, and `busy` is low in that cycle. A `start` is accepted only while both are low, and a `start` raised during a walk has no effect on that walk or on later reads.
- R11: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays valid with an unchanged address.
- R12: No new request is issued until the response to the previous one has arrived.

Top module ports in order:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| va | input | 39 | Virtual address to translate |
| root_ppn | input | 28 | Frame number of the top-level table |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle pulse: result outputs are valid |
| pa | output | 40 | Translated physical address |
| perm | output | 3 | Permission bits of the leaf |
| fault | output | 1 | Walk ended in a fault |
| fault_cause | output | 2 | 0 none, 1 invalid entry, 2 non-leaf at last level, 3 misaligned superpage |
| end_level | output | 2 | Level at which the walk ended (0 = top) |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_addr | output | 40 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Entry read from memory |

## Verification
A wrong level counter or stale table base shows up within one request handshake as an entry address off its expected value. For that reason the bench logs every request address and compares it with the address computed from the fields. A decode slip, such as a wrong leaf, valid or alignment test, changes the number of reads a walk makes and the cause reported at `done`. Both are visible at most three responses after the start. Control errors show up as a missing or doubled `done` pulse, a second outstanding read, or a request address that moves while stalled.

// File: rtl/pw_pkg.sv
package pw_pkg;
  parameter int LEVELS   = 3;
  parameter int IDX_W    = 9;
  parameter int OFF_W    = 12;
  parameter int VA_W     = OFF_W + LEVELS * IDX_W;
  parameter int PA_W     = 40;
  parameter int PPN_W    = PA_W - OFF_W;
  parameter int PTE_W    = 64;
  parameter int PERM_W   = 3;
  parameter int PERM_LSB = 2;
  parameter int ENT_LG2  = 3;
  parameter int LVL_W    = $clog2(LEVELS);

  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} walk_state_e;
  typedef enum logic [1:0] {STEP_NEXT, STEP_LEAF, STEP_FAULT} step_kind_e;
  typedef enum logic [1:0] {
    FC_NONE = 2'd0, FC_INVALID = 2'd1, FC_NOT_LEAF = 2'd2, FC_MISALIGN = 2'd3
  } fault_cause_e;

  // Number of address bits a mapping at this level covers.
  function automatic int span_bits(input logic [LVL_W-1:0] lvl);
    return OFF_W + IDX_W * (LEVELS - 1 - int'(lvl));
  endfunction

  function automatic logic [PA_W-1:0] low_mask(input logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] one;
    one = PA_W'(1);
    return (one << span_bits(lvl)) - one;
  endfunction

  function automatic logic [PA_W-1:0] entry_addr(input logic [PPN_W-1:0] base,
                                                 input logic [IDX_W-1:0] idx);
    return {base, {OFF_W{1'b0}}} + PA_W'({idx, {ENT_LG2{1'b0}}});
  endfunction

  function automatic logic is_misaligned(input logic [PPN_W-1:0] ppn,
                                         input logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] full;
    full = {ppn, {OFF_W{1'b0}}};
    return (full & low_mask(lvl)) != '0;
  endfunction

  function automatic logic [PA_W-1:0] compose_pa(input logic [PPN_W-1:0] ppn,
                                                 input logic [VA_W-1:0] va,
                                                 input logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] full, mask;
    full = {ppn, {OFF_W{1'b0}}};
    mask = low_mask(lvl);
    return (full & ~mask) | (PA_W'(va) & mask);
  endfunction
endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel
  import pw_pkg::*;
(
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] lvl,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] fields [LEVELS];

  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign fields[g] = va[OFF_W + IDX_W * (LEVELS - 1 - g) +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++)
      if (LVL_W'(i) == lvl) idx = fields[i];
  end
endmodule

// File: rtl/pw_pte_decode.sv
module pw_pte_decode
  import pw_pkg::*;
(
  input  logic [PTE_W-1:0]  pte,
  input  logic [LVL_W-1:0]  lvl,
  output step_kind_e        kind,
  output fault_cause_e      cause,
  output logic [PPN_W-1:0]  ppn,
  output logic [PERM_W-1:0] perm
);
  logic valid, leaf, last;
  logic unused_pte;

  assign valid = pte[0];
  assign leaf  = pte[1];
  assign ppn   = pte[OFF_W +: PPN_W];
  assign perm  = pte[PERM_LSB +: PERM_W];
  assign last  = (lvl == LVL_W'(LEVELS - 1));
  assign unused_pte = ^{pte[PTE_W-1:PA_W], pte[OFF_W-1:PERM_LSB+PERM_W]};

  always_comb begin
    kind  = STEP_NEXT;
    cause = FC_NONE;
    if (!valid) begin
      kind  = STEP_FAULT;
      cause = FC_INVALID;
    end else if (!leaf && last) begin
      kind  = STEP_FAULT;
      cause = FC_NOT_LEAF;
    end else if (leaf && is_misaligned(ppn, lvl)) begin
      kind  = STEP_FAULT;
      cause = FC_MISALIGN;
    end else if (leaf) begin
      kind  = STEP_LEAF;
    end
  end

  // R8: the alignment fault can only come from an upper-level leaf
  always_comb begin
    p_misalign_upper_r8: assert (!(cause == FC_MISALIGN && last));
  end
endmodule

// File: rtl/pw_ctrl.sv
module pw_ctrl
  import pw_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic        mem_req_ready,
  input  logic        mem_rsp_valid,
  input  step_kind_e  kind,
  output walk_state_e state,
  output logic        ev_accept,
  output logic        ev_issue,
  output logic        ev_descend,
  output logic        ev_finish
);
  walk_state_e state_n;
  logic        ev_rsp;

  assign ev_accept  = (state == ST_IDLE) && start;
  assign ev_issue   = (state == ST_REQ) && mem_req_ready;
  assign ev_rsp     = (state == ST_WAIT) && mem_rsp_valid;
  assign ev_descend = ev_rsp && (kind == STEP_NEXT);
  assign ev_finish  = ev_rsp && (kind != STEP_NEXT);

  always_comb begin
    state_n = state;
    unique case (state)
      ST_IDLE: if (ev_accept) state_n = ST_REQ;
      ST_REQ:  if (ev_issue)  state_n = ST_WAIT;
      ST_WAIT: begin
        if (ev_descend)     state_n = ST_REQ;
        else if (ev_finish) state_n = ST_DONE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_n;
  end

  // R12: after a handshake the walker waits for data before asking again
  p_wait_after_issue_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ev_issue |=> (state == ST_WAIT));
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [VA_W-1:0]   va,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              busy,
  output logic              done,
  output logic [PA_W-1:0]   pa,
  output logic [PERM_W-1:0] perm,
  output logic              fault,
  output logic [1:0]        fault_cause,
  output logic [LVL_W-1:0]  end_level,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [PTE_W-1:0]  mem_rsp_data
);
  walk_state_e       state;
  step_kind_e        kind;
  fault_cause_e      cause;
  logic              ev_accept, ev_issue, ev_descend, ev_finish;
  logic [VA_W-1:0]   va_q;
  logic [PPN_W-1:0]  base_q;
  logic [LVL_W-1:0]  lvl_q;
  logic [IDX_W-1:0]  idx;
  logic [PPN_W-1:0]  ent_ppn;
  logic [PERM_W-1:0] ent_perm;
  logic [PA_W-1:0]   pa_q;
  logic [PERM_W-1:0] perm_q;
  logic              fault_q;
  fault_cause_e      cause_q;
  logic [LVL_W-1:0]  end_q;

  pw_ctrl u_ctrl (
    .clk, .rst_n, .start, .mem_req_ready, .mem_rsp_valid,
    .kind, .state, .ev_accept, .ev_issue, .ev_descend, .ev_finish
  );

  pw_index_sel u_idx (.va(va_q), .lvl(lvl_q), .idx(idx));

  pw_pte_decode u_dec (
    .pte(mem_rsp_data), .lvl(lvl_q), .kind, .cause, .ppn(ent_ppn), .perm(ent_perm)
  );

  // Walk context: captured at accept, advanced on each descent
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q   <= '0;
      base_q <= '0;
      lvl_q  <= '0;
    end else if (ev_accept) begin
      va_q   <= va;
      base_q <= root_ppn;
      lvl_q  <= '0;
    end else if (ev_descend) begin
      base_q <= ent_ppn;
      lvl_q  <= lvl_q + LVL_W'(1);
    end
  end

  // Result registers: written once per walk at its last step
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q    <= '0;
      perm_q  <= '0;
      fault_q <= 1'b0;
      cause_q <= FC_NONE;
      end_q   <= '0;
    end else if (ev_finish) begin
      end_q <= lvl_q;
      if (kind == STEP_LEAF) begin
        pa_q    <= compose_pa(ent_ppn, va_q, lvl_q);
        perm_q  <= ent_perm;
        fault_q <= 1'b0;
        cause_q <= FC_NONE;
      end else begin
        pa_q    <= '0;
        perm_q  <= '0;
        fault_q <= 1'b1;
        cause_q <= cause;
      end
    end
  end

  assign busy          = (state == ST_REQ) || (state == ST_WAIT);
  assign done          = (state == ST_DONE);
  assign mem_req_valid = (state == ST_REQ);
  assign mem_req_addr  = entry_addr(base_q, idx);
  assign pa            = pa_q;
  assign perm          = perm_q;
  assign fault         = fault_q;
  assign fault_cause   = cause_q;
  assign end_level     = end_q;

  // R11: a stalled request keeps its address
  p_req_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R10: done lasts one cycle
  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: a start during a walk leaves the captured address alone
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(va_q));

  // R7: descent never happens from the last level
  p_descend_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_descend |-> (lvl_q != LVL_W'(LEVELS - 1)));

  // R4: a 1 GiB leaf passes the low 30 virtual bits through
  p_giga_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && end_level == LVL_W'(0)) |->
      (pa[OFF_W+2*IDX_W-1:0] == va_q[OFF_W+2*IDX_W-1:0]));

  // R5: a 2 MiB leaf passes the low 21 virtual bits through
  p_mega_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault && end_level == LVL_W'(1)) |->
      (pa[OFF_W+IDX_W-1:0] == va_q[OFF_W+IDX_W-1:0]));
endmodule

// File: tb/pt_walker_tb.sv
`timescale 1ns/1ps
module pt_walker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [38:0] va_in = '0;
  logic [27:0] root_in = '0;
  logic        busy, done, fault, mem_req_valid;
  logic [39:0] pa, mem_req_addr;
  logic [2:0]  perm;
  logic [1:0]  fault_cause, end_level;
  logic        mem_req_ready = 1'b1;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  pt_walker u_dut (
    .clk, .rst_n, .start, .va(va_in), .root_ppn(root_in), .busy, .done, .pa, .perm,
    .fault, .fault_cause, .end_level, .mem_req_valid, .mem_req_ready, .mem_req_addr,
    .mem_rsp_valid, .mem_rsp_data
  );

  always #4 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  // Behavioural memory
  logic [63:0] mem [logic [39:0]];
  logic [39:0] addr_log [$];
  int   lat = 0, stall_mod = 0, cyc = 0, req_count = 0, overlap = 0, cnt = 0;
  bit   pend = 0;
  logic [39:0] pend_addr = '0;

  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(pend_addr) ? mem[pend_addr] : 64'h0;
        pend = 0;
      end else cnt--;
    end
    mem_req_ready = (stall_mod == 0) || (cyc % stall_mod == 0);
    if (mem_req_valid && mem_req_ready) begin
      if (pend || mem_rsp_valid) overlap++;
      pend = 1; pend_addr = mem_req_addr; cnt = lat;
      req_count++;
      addr_log.push_back(mem_req_addr);
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [38:0] mk_va(input int i0, input int i1, input int i2, input int off);
    return 39'(i0) * 39'h4000_0000 + 39'(i1) * 39'h20_0000 + 39'(i2) * 39'h1000 + 39'(off);
  endfunction
  function automatic logic [63:0] pte_next(input logic [27:0] p);
    return 64'(p) * 64'h1000 + 64'h1;
  endfunction
  function automatic logic [63:0] pte_leaf(input logic [27:0] p, input logic [2:0] pm);
    return 64'(p) * 64'h1000 + 64'(pm) * 64'h4 + 64'h3;
  endfunction
  function automatic logic [39:0] ent(input logic [27:0] base, input int idx);
    return 40'(base) * 40'h1000 + 40'(idx) * 40'h8;
  endfunction
  function automatic logic [39:0] exp_pa(input logic [27:0] p, input logic [38:0] v, input int lvl);
    logic [63:0] m;
    m = (64'h1 << (12 + 9 * (2 - lvl))) - 64'h1;
    return 40'(((64'(p) << 12) & ~m) | (64'(v) & m));
  endfunction

  localparam logic [27:0] ROOT = 28'h00100, TB1 = 28'h00200, TB2 = 28'h00300;

  logic [39:0] r_pa; logic [2:0] r_perm; logic r_fault, r_seen, r_after, r_busy;
  logic [1:0] r_cause, r_lvl;

  task automatic do_walk(input logic [38:0] v, input logic [27:0] root);
    int n;
    req_count = 0; addr_log.delete();
    @(negedge clk);
    start = 1'b1; va_in = v; root_in = root;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    r_seen = done; r_pa = pa; r_perm = perm; r_fault = fault;
    r_cause = fault_cause; r_lvl = end_level; r_busy = busy;
    @(negedge clk);
    r_after = done;
  endtask

  task automatic check_pulse(input string tag);
    chk(r_seen, {tag, "/R10 done seen"}, 64'(r_seen), 1);
    chk(!r_busy, "R10 busy low at done", 64'(r_busy), 0);
    chk(!r_after, "R10 done one cycle", 64'(r_after), 0);
  endtask

  task automatic expect_leaf(input string tag, input logic [39:0] epa, input int elvl,
                             input logic [2:0] eperm, input int reads);
    check_pulse(tag);
    chk(r_pa == epa, {tag, " pa"}, 64'(r_pa), 64'(epa));
    chk(r_lvl == 2'(elvl), {tag, " end_level"}, 64'(r_lvl), 64'(elvl));
    chk(req_count == reads, {tag, " read count"}, 64'(req_count), 64'(reads));
    chk(!r_fault && r_cause == 2'd0, "R9 no fault", 64'({r_fault, r_cause}), 0);
    chk(r_perm == eperm, "R9 perm", 64'(r_perm), 64'(eperm));
  endtask

  task automatic expect_fault(input string tag, input int ecause, input int elvl, input int reads);
    check_pulse(tag);
    chk(r_fault == 1'b1, {tag, " fault"}, 64'(r_fault), 1);
    chk(r_cause == 2'(ecause), {tag, " cause"}, 64'(r_cause), 64'(ecause));
    chk(r_lvl == 2'(elvl), {tag, " end_level"}, 64'(r_lvl), 64'(elvl));
    chk(req_count == reads, {tag, " read count"}, 64'(req_count), 64'(reads));
  endtask

  task automatic t_reset();
    chk(!busy && !done && !mem_req_valid, "R1 idle after reset",
        64'({busy, done, mem_req_valid}), 0);
  endtask

  task automatic t_page4k(input int l, input int s, input string tag);
    logic [38:0] v;
    mem.delete(); lat = l; stall_mod = s;
    v = mk_va(5, 'h1A3, 'h0FF, 'hABC);
    mem[ent(ROOT, 5)]     = pte_next(TB1);
    mem[ent(TB1, 'h1A3)]  = pte_next(TB2);
    mem[ent(TB2, 'h0FF)]  = pte_leaf(28'h12345, 3'b101);
    do_walk(v, ROOT);
    expect_leaf(tag, exp_pa(28'h12345, v, 2), 2, 3'b101, 3);
    if (addr_log.size() == 3) begin
      chk(addr_log[0] == ent(ROOT, 5), "R2 addr L0", 64'(addr_log[0]), 64'(ent(ROOT, 5)));
      chk(addr_log[1] == ent(TB1, 'h1A3), "R2 addr L1", 64'(addr_log[1]), 64'(ent(TB1, 'h1A3)));
      chk(addr_log[2] == ent(TB2, 'h0FF), "R2 addr L2", 64'(addr_log[2]), 64'(ent(TB2, 'h0FF)));
    end
    lat = 0; stall_mod = 0;
  endtask

  task automatic t_giga();
    logic [38:0] v;
    mem.delete();
    v = mk_va(7, 'h155, 'h0AA, 'h123);
    mem[ent(ROOT, 7)] = pte_leaf(28'hC0000, 3'b011);
    do_walk(v, ROOT);
    expect_leaf("R4 1GiB leaf", exp_pa(28'hC0000, v, 0), 0, 3'b011, 1);
  endtask

  task automatic t_mega();
    logic [38:0] v;
    mem.delete();
    v = mk_va(2, 'h0C1, 'h1F0, 'hFFF);
    mem[ent(ROOT, 2)]    = pte_next(TB1);
    mem[ent(TB1, 'h0C1)] = pte_leaf(28'h30200, 3'b110);
    do_walk(v, ROOT);
    expect_leaf("R5 2MiB leaf", exp_pa(28'h30200, v, 1), 1, 3'b110, 2);
  endtask

  task automatic t_invalid();
    logic [38:0] v;
    v = mk_va(3, 'h011, 'h022, 'h0);
    for (int lvl = 0; lvl < 3; lvl++) begin
      mem.delete();
      if (lvl > 0) mem[ent(ROOT, 3)] = pte_next(TB1);
      if (lvl > 1) mem[ent(TB1, 'h011)] = pte_next(TB2);
      if (lvl == 0) mem[ent(ROOT, 3)] = 64'h0000_0000_0555_5000;
      do_walk(v, ROOT);
      expect_fault("R6 invalid entry", 1, lvl, lvl + 1);
    end
  endtask

  task automatic t_not_leaf();
    logic [38:0] v;
    mem.delete();
    v = mk_va(1, 'h002, 'h003, 'h7);
    mem[ent(ROOT, 1)]    = pte_next(TB1);
    mem[ent(TB1, 'h002)] = pte_next(TB2);
    mem[ent(TB2, 'h003)] = pte_next(28'h00400);
    do_walk(v, ROOT);
    expect_fault("R7 pointer at last level", 2, 2, 3);
  endtask

  task automatic t_misalign();
    logic [38:0] v;
    mem.delete();
    v = mk_va(4, 'h010, 'h020, 'h30);
    mem[ent(ROOT, 4)] = pte_leaf(28'hC0001, 3'b111);
    do_walk(v, ROOT);
    expect_fault("R8 misaligned 1GiB", 3, 0, 1);
    mem.delete();
    mem[ent(ROOT, 4)]    = pte_next(TB1);
    mem[ent(TB1, 'h010)] = pte_leaf(28'h30300, 3'b111);
    do_walk(v, ROOT);
    expect_fault("R8 misaligned 2MiB", 3, 1, 2);
  endtask

  task automatic t_start_busy();
    logic [38:0] va_a, va_b;
    int n, extra;
    mem.delete(); lat = 20;
    va_a = mk_va(5, 'h1A3, 'h0FF, 'h044);
    va_b = mk_va(7, 'h000, 'h000, 'h000);
    mem[ent(ROOT, 5)]    = pte_next(TB1);
    mem[ent(TB1, 'h1A3)] = pte_next(TB2);
    mem[ent(TB2, 'h0FF)] = pte_leaf(28'h0ABCD, 3'b001);
    mem[ent(ROOT, 7)]    = pte_leaf(28'h40000, 3'b010);
    req_count = 0; addr_log.delete();
    @(negedge clk); start = 1'b1; va_in = va_a; root_in = ROOT;
    @(negedge clk); start = 1'b0;
    repeat (5) @(negedge clk);
    start = 1'b1; va_in = va_b; root_in = TB2;
    @(negedge clk); start = 1'b0;
    n = 0;
    while (!done && n < 2000) begin @(negedge clk); n++; end
    chk(done == 1'b1, "R10 first walk completes", 64'(done), 1);
    chk(pa == exp_pa(28'h0ABCD, va_a, 2), "R10 start during walk ignored",
        64'(pa), 64'(exp_pa(28'h0ABCD, va_a, 2)));
    extra = 0;
    repeat (60) begin @(negedge clk); if (done) extra++; end
    chk(extra == 0, "R10 no second walk", 64'(extra), 0);
    chk(req_count == 3, "R10 reads of one walk only", 64'(req_count), 3);
    lat = 0;
  endtask

  initial begin
    #(8ns * 150000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_page4k(0, 0, "R3 4KiB walk");
    t_page4k(3, 3, "R11 stalled 4KiB walk");
    t_giga();
    t_mega();
    t_invalid();
    t_not_leaf();
    t_misalign();
    t_start_busy();
    chk(overlap == 0, "R12 single outstanding read", 64'(overlap), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule